// File: doc/BRIEF.md
# Register Slave with Acknowledge, Error and Retry Terminations

This block is a bus-attached register slave. A master opens a cycle, raises its strobe with an address, a write flag, write data and lane selects. One clock after the slave samples cycle and strobe both high, it ends the transfer with exactly one of three terminations. The terminations are acknowledge for a completed access, error for an address nothing answers to, and retry for a region the slave cannot serve right now. Each termination stays up while the master keeps the cycle open with strobe low. It clears when strobe is seen high again or when the cycle closes.

Behind the slave sits a small bank of data registers and one control register. Bit 0 of the control register is a busy flag. While the flag is set, every access to a configurable address window inside the bank is turned away with retry. Read data is captured only on acknowledged reads. It then stays frozen, so the master can sample it at any point while the termination is held.

Top module: `tri_resp_slave`

## Requirements
- R1: A synchronous active-low reset holds acknowledge, error and retry low. It also clears every data register to zero and clears the busy flag, so a read of the control register (address 0x0F) returns 0.
- R2: While the cycle input is low, acknowledge, error and retry are all low in that same clock. A strobe or write with the cycle input low changes no register.
- R3: At most one of acknowledge, error and retry is high in any clock. Each accepted request ends with exactly one of them.
- R4: A termination that is high while the cycle is open and strobe is low is still the same termination on the next clock.
- R5: While an acknowledged read is held with strobe low, the read-data output does not change.
- R6: A termination appears on the clock after cycle and strobe are sampled high with no termination showing. It drops on the clock after strobe is seen high again, and the next request is served one clock later.
- R7: A write updates only the 8-bit data lanes whose select bit is set. A write with all selects low still acknowledges and leaves the register unchanged.
- R8: The mapped addresses are data registers 0x00 to 0x07 and the control register 0x0F. Any other address ends with error, and a write to it changes no register.
- R9: When the busy flag is set, an access to addresses 0x04 to 0x07 ends with retry and changes no register. The same access is acknowledged when the flag is clear. The control register and the other data registers are never busy.
- R10: The read-data output takes the addressed register's value only on an acknowledged read. It holds its previous value across writes, error and retry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cyc_i | input | 1 | Bus cycle open |
| stb_i | input | 1 | Transfer request strobe |
| we_i | input | 1 | Write when high, read when low |
| adr_i | input | ADDR_W (8) | Register address |
| dat_i | input | DATA_W (8) | Write data |
| sel_i | input | DATA_W/8 (1) | Lane select, one bit per 8-bit lane |
| dat_o | output | DATA_W (8) | Read data, captured on acknowledged reads |
| ack_o | output | 1 | Normal termination |
| err_o | output | 1 | Error termination |
| rty_o | output | 1 | Retry termination |

## Verification
The hardest state to reach from the ports is a held termination. The cycle has to stay open with strobe low across several clocks, and then a fresh strobe must knock the termination down before the next one rises. The bench drives the open-cycle hold directly, once on an acknowledged read and once on an error. It then raises strobe with a new address and checks the idle gap clock followed by the new acknowledge. Retry needs the busy flag set first through a control-register write. The bench does that before probing the window and clears the flag afterwards to show the same address acknowledges again with its old contents.

// File: rtl/tri_resp_pkg.sv
`timescale 1ns/1ps
package tri_resp_pkg;
    typedef enum logic [1:0] {
        TERM_NONE = 2'd0,
        TERM_ACK  = 2'd1,
        TERM_ERR  = 2'd2,
        TERM_RTY  = 2'd3
    } term_e;
endpackage

// File: rtl/tri_resp_decode.sv
`timescale 1ns/1ps
module tri_resp_decode
    import tri_resp_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_REGS  = 8,
    parameter int CTRL_ADDR = 15,
    parameter int BUSY_LO   = 4,
    parameter int BUSY_HI   = 7,
    parameter int IDX_W     = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy,
    output term_e             kind,
    output logic              hit_ctrl,
    output logic [IDX_W-1:0]  idx
);
    logic in_bank;
    logic in_window;

    always_comb begin
        in_bank   = addr < ADDR_W'(NUM_REGS);
        hit_ctrl  = addr == ADDR_W'(CTRL_ADDR);
        in_window = (addr >= ADDR_W'(BUSY_LO)) && (addr <= ADDR_W'(BUSY_HI));
        idx       = addr[IDX_W-1:0];
        if (!(in_bank || hit_ctrl)) begin
            kind = TERM_ERR;
        end else if (busy && in_bank && in_window) begin
            kind = TERM_RTY;
        end else begin
            kind = TERM_ACK;
        end
    end
endmodule

// File: rtl/tri_resp_regbank.sv
`timescale 1ns/1ps
module tri_resp_regbank #(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 8,
    parameter int IDX_W    = 3,
    parameter int SEL_W    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              hit_ctrl,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SEL_W-1:0]  sel,
    output logic              busy,
    output logic [DATA_W-1:0] rd_value
);
    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
        logic                            busy;
    } bank_st;

    bank_st bank_q, bank_d;
    logic [DATA_W-1:0] lane_mask;

    for (genvar l = 0; l < SEL_W; l++) begin : g_lane
        assign lane_mask[l*8 +: 8] = {8{sel[l]}};
    end

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            if (hit_ctrl) begin
                if (sel[0]) begin
                    bank_d.busy = wdata[0];
                end
            end else begin
                bank_d.regs[idx] = (bank_q.regs[idx] & ~lane_mask) | (wdata & lane_mask);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign busy     = bank_q.busy;
    assign rd_value = hit_ctrl ? {{(DATA_W-1){1'b0}}, bank_q.busy} : bank_q.regs[idx];

    AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bank_q)); // R2
endmodule

// File: rtl/tri_resp_term.sv
`timescale 1ns/1ps
module tri_resp_term
    import tri_resp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_i,
    input  logic              stb_i,
    input  logic              we_i,
    input  term_e             kind,
    input  logic [DATA_W-1:0] rd_value,
    output logic              accept,
    output term_e             term,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        term_e             term;
        logic [DATA_W-1:0] rdata;
    } term_st;

    term_st st_q, st_d;

    assign accept = cyc_i && stb_i && (st_q.term == TERM_NONE);

    always_comb begin
        st_d = st_q;
        if (!cyc_i) begin
            st_d.term = TERM_NONE;
        end else if (st_q.term != TERM_NONE) begin
            if (stb_i) begin
                st_d.term = TERM_NONE;
            end
        end else if (stb_i) begin
            st_d.term = kind;
            if (kind == TERM_ACK && !we_i) begin
                st_d.rdata = rd_value;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign term  = st_q.term;
    assign rdata = st_q.rdata;

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> st_q.term == TERM_NONE); // R1
    AST_TERM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_i && !stb_i && st_q.term != TERM_NONE |=> st_q.term == $past(st_q.term)); // R4
    AST_READ_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_i && !stb_i && !we_i && st_q.term == TERM_ACK |=> $stable(st_q.rdata)); // R5
    AST_RDATA_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && kind == TERM_ACK && !we_i) |=> $stable(st_q.rdata)); // R10
endmodule

// File: rtl/tri_resp_slave.sv
`timescale 1ns/1ps
module tri_resp_slave
    import tri_resp_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int NUM_REGS  = 8,
    parameter int CTRL_ADDR = 15,
    parameter int BUSY_LO   = 4,
    parameter int BUSY_HI   = 7,
    localparam int SEL_W    = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_i,
    input  logic              stb_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] adr_i,
    input  logic [DATA_W-1:0] dat_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic [DATA_W-1:0] dat_o,
    output logic              ack_o,
    output logic              err_o,
    output logic              rty_o
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    term_e             kind;
    term_e             term;
    logic              hit_ctrl;
    logic [IDX_W-1:0]  idx;
    logic              busy;
    logic [DATA_W-1:0] rd_value;
    logic              accept;
    logic              wr_en;

    tri_resp_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS),
        .CTRL_ADDR(CTRL_ADDR),
        .BUSY_LO  (BUSY_LO),
        .BUSY_HI  (BUSY_HI),
        .IDX_W    (IDX_W)
    ) u_decode (
        .addr    (adr_i),
        .busy    (busy),
        .kind    (kind),
        .hit_ctrl(hit_ctrl),
        .idx     (idx)
    );

    assign wr_en = accept && we_i && (kind == TERM_ACK);

    tri_resp_regbank #(
        .DATA_W  (DATA_W),
        .NUM_REGS(NUM_REGS),
        .IDX_W   (IDX_W),
        .SEL_W   (SEL_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .hit_ctrl(hit_ctrl),
        .idx     (idx),
        .wdata   (dat_i),
        .sel     (sel_i),
        .busy    (busy),
        .rd_value(rd_value)
    );

    tri_resp_term #(
        .DATA_W(DATA_W)
    ) u_term (
        .clk     (clk),
        .rst_n   (rst_n),
        .cyc_i   (cyc_i),
        .stb_i   (stb_i),
        .we_i    (we_i),
        .kind    (kind),
        .rd_value(rd_value),
        .accept  (accept),
        .term    (term),
        .rdata   (dat_o)
    );

    assign ack_o = cyc_i && (term == TERM_ACK);
    assign err_o = cyc_i && (term == TERM_ERR);
    assign rty_o = cyc_i && (term == TERM_RTY);

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_i |-> !(ack_o || err_o || rty_o)); // R2
    AST_ONE_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ack_o, err_o, rty_o})); // R3
    AST_ONE_CLOCK_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_i && stb_i && !(ack_o || err_o || rty_o) |=> (ack_o || err_o || rty_o) || !cyc_i); // R6
    AST_RETRY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        accept && busy && adr_i >= ADDR_W'(BUSY_LO) && adr_i <= ADDR_W'(BUSY_HI)
        && adr_i < ADDR_W'(NUM_REGS) |=> rty_o || !cyc_i); // R9
endmodule

// File: tb/tb_tri_resp_slave.sv
`timescale 1ns/1ps
module tb_tri_resp_slave;
    localparam real CLK_HALF = 2.5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_i = 1'b0;
    logic       stb_i = 1'b0;
    logic       we_i = 1'b0;
    logic [7:0] adr_i = '0;
    logic [7:0] dat_i = '0;
    logic [0:0] sel_i = '0;
    logic [7:0] dat_o;
    logic       ack_o, err_o, rty_o;

    int total = 0;
    int bad = 0;

    logic [7:0] m_bank [8];
    logic       m_busy;
    logic [7:0] m_rdata;

    localparam logic [2:0] C_NONE = 3'b000;
    localparam logic [2:0] C_ACK  = 3'b001;
    localparam logic [2:0] C_ERR  = 3'b010;
    localparam logic [2:0] C_RTY  = 3'b100;

    always #(CLK_HALF) clk = ~clk;

    tri_resp_slave dut (
        .clk  (clk),
        .rst_n(rst_n),
        .cyc_i(cyc_i),
        .stb_i(stb_i),
        .we_i (we_i),
        .adr_i(adr_i),
        .dat_i(dat_i),
        .sel_i(sel_i),
        .dat_o(dat_o),
        .ack_o(ack_o),
        .err_o(err_o),
        .rty_o(rty_o)
    );

    function automatic logic [2:0] code_now();
        return {rty_o, err_o, ack_o};
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] model_code(input logic [7:0] a);
        if (!(a < 8 || a == 8'h0F)) return C_ERR;
        if (m_busy && a >= 4 && a <= 7) return C_RTY;
        return C_ACK;
    endfunction

    function automatic logic [7:0] model_read(input logic [7:0] a);
        if (a == 8'h0F) return {7'b0, m_busy};
        return m_bank[a[2:0]];
    endfunction

    task automatic model_clear();
        for (int i = 0; i < 8; i++) m_bank[i] = '0;
        m_busy  = 1'b0;
        m_rdata = '0;
    endtask

    // One complete transfer, started and ended on a falling edge with the bus idle.
    task automatic xfer(input string req, input logic we, input logic [7:0] a,
                        input logic [7:0] d, input logic s);
        logic [2:0] exp;
        exp   = model_code(a);
        cyc_i = 1'b1; stb_i = 1'b1; we_i = we; adr_i = a; dat_i = d; sel_i = s;
        @(posedge clk);
        @(negedge clk);
        check(req, "termination", {29'b0, code_now()}, {29'b0, exp});
        if (exp == C_ACK) begin
            if (!we) m_rdata = model_read(a);
            else if (a == 8'h0F) begin
                if (s) m_busy = d[0];
            end else if (s) m_bank[a[2:0]] = d;
        end
        check(req, "read data", {24'b0, dat_o}, {24'b0, m_rdata});
        cyc_i = 1'b0; stb_i = 1'b0;
        #1;
        check("R2", "cycle closed", {29'b0, code_now()}, {29'b0, C_NONE});
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cyc_i = 1'b1; stb_i = 1'b1; we_i = 1'b1; adr_i = 8'h02; dat_i = 8'h5A; sel_i = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            @(negedge clk);
            check("R1", "terminations in reset", {29'b0, code_now()}, {29'b0, C_NONE});
        end
        cyc_i = 1'b0; stb_i = 1'b0; we_i = 1'b0;
        rst_n = 1'b1;
        model_clear();
        @(negedge clk);
        for (int i = 0; i < 8; i++) xfer("R1", 1'b0, 8'(i), 8'h00, 1'b1);
        xfer("R1", 1'b0, 8'h0F, 8'h00, 1'b1);
    endtask

    task automatic t_idle();
        cyc_i = 1'b0; stb_i = 1'b1; we_i = 1'b1; adr_i = 8'h02; dat_i = 8'hC3; sel_i = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            @(negedge clk);
            check("R2", "strobe without cycle", {29'b0, code_now()}, {29'b0, C_NONE});
        end
        stb_i = 1'b0; we_i = 1'b0;
        @(negedge clk);
        xfer("R2", 1'b0, 8'h02, 8'h00, 1'b1);
    endtask

    task automatic t_rw();
        xfer("R3", 1'b1, 8'h00, 8'h11, 1'b1);
        xfer("R3", 1'b1, 8'h03, 8'hA5, 1'b1);
        xfer("R3", 1'b1, 8'h07, 8'hFF, 1'b1);
        xfer("R10", 1'b0, 8'h03, 8'h00, 1'b1);
        xfer("R10", 1'b1, 8'h01, 8'h3C, 1'b1);
        check("R10", "data after write", {24'b0, dat_o}, 32'hA5);
        xfer("R3", 1'b0, 8'h00, 8'h00, 1'b1);
        xfer("R3", 1'b0, 8'h07, 8'h00, 1'b1);
        xfer("R3", 1'b0, 8'h01, 8'h00, 1'b1);
    endtask

    task automatic t_lanes();
        xfer("R7", 1'b1, 8'h02, 8'h77, 1'b1);
        xfer("R7", 1'b1, 8'h02, 8'h99, 1'b0);
        xfer("R7", 1'b0, 8'h02, 8'h00, 1'b1);
        check("R7", "unselected lane kept", {24'b0, dat_o}, 32'h77);
    endtask

    task automatic t_unmapped();
        xfer("R8", 1'b1, 8'h20, 8'hEE, 1'b1);
        xfer("R8", 1'b1, 8'h08, 8'hEE, 1'b1);
        xfer("R10", 1'b0, 8'h30, 8'h00, 1'b1);
        xfer("R8", 1'b0, 8'hFF, 8'h00, 1'b1);
        xfer("R8", 1'b0, 8'h00, 8'h00, 1'b1);
        check("R8", "alias untouched", {24'b0, dat_o}, 32'h11);
    endtask

    task automatic t_busy();
        xfer("R9", 1'b1, 8'h05, 8'h42, 1'b1);
        xfer("R9", 1'b1, 8'h0F, 8'h01, 1'b1);
        xfer("R9", 1'b0, 8'h0F, 8'h00, 1'b1);
        check("R9", "busy flag read", {24'b0, dat_o}, 32'h01);
        xfer("R9", 1'b1, 8'h05, 8'hDD, 1'b1);
        xfer("R9", 1'b0, 8'h05, 8'h00, 1'b1);
        xfer("R9", 1'b0, 8'h04, 8'h00, 1'b1);
        xfer("R9", 1'b1, 8'h03, 8'h6B, 1'b1);
        xfer("R9", 1'b0, 8'h03, 8'h00, 1'b1);
        xfer("R9", 1'b1, 8'h0F, 8'h00, 1'b1);
        xfer("R9", 1'b0, 8'h05, 8'h00, 1'b1);
        check("R9", "window kept old value", {24'b0, dat_o}, 32'h42);
    endtask

    task automatic t_hold();
        cyc_i = 1'b1; stb_i = 1'b1; we_i = 1'b0; adr_i = 8'h03; sel_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R6", "first termination", {29'b0, code_now()}, {29'b0, C_ACK});
        m_rdata = m_bank[3];
        stb_i = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            @(negedge clk);
            check("R4", "ack held", {29'b0, code_now()}, {29'b0, C_ACK});
            check("R5", "read data frozen", {24'b0, dat_o}, {24'b0, m_rdata});
        end
        stb_i = 1'b1; adr_i = 8'h01;
        @(posedge clk);
        @(negedge clk);
        check("R6", "gap after new strobe", {29'b0, code_now()}, {29'b0, C_NONE});
        @(posedge clk);
        @(negedge clk);
        check("R6", "second termination", {29'b0, code_now()}, {29'b0, C_ACK});
        m_rdata = m_bank[1];
        check("R6", "second read data", {24'b0, dat_o}, {24'b0, m_rdata});
        stb_i = 1'b0;
        adr_i = 8'h40;
        @(posedge clk);
        @(negedge clk);
        check("R4", "ack held with address change", {29'b0, code_now()}, {29'b0, C_ACK});
        cyc_i = 1'b0;
        #1;
        check("R2", "cycle dropped during hold", {29'b0, code_now()}, {29'b0, C_NONE});
        @(negedge clk);
        cyc_i = 1'b1; stb_i = 1'b1; adr_i = 8'h40;
        @(posedge clk);
        @(negedge clk);
        check("R8", "error on unmapped", {29'b0, code_now()}, {29'b0, C_ERR});
        stb_i = 1'b0;
        for (int i = 0; i < 2; i++) begin
            @(posedge clk);
            @(negedge clk);
            check("R4", "error held", {29'b0, code_now()}, {29'b0, C_ERR});
            check("R10", "data kept on error", {24'b0, dat_o}, {24'b0, m_rdata});
        end
        cyc_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset_again();
        xfer("R1", 1'b1, 8'h0F, 8'h01, 1'b1);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1", "terminations in reset", {29'b0, code_now()}, {29'b0, C_NONE});
        rst_n = 1'b1;
        model_clear();
        @(negedge clk);
        xfer("R1", 1'b0, 8'h0F, 8'h00, 1'b1);
        xfer("R1", 1'b0, 8'h05, 8'h00, 1'b1);
        xfer("R1", 1'b0, 8'h03, 8'h00, 1'b1);
    endtask

    initial begin
        #(CLK_HALF * 2.0 * 150000.0);
        total++;
        bad++;
        $display("FAIL watchdog all requirements actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        model_clear();
        @(negedge clk);
        t_reset();
        t_idle();
        t_rw();
        t_lanes();
        t_unmapped();
        t_busy();
        t_hold();
        t_reset_again();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule